// File: doc/BRIEF.md
# Timed Device Reset Sequencer with Bounded Retry

This block lets a host bring an attached device out of a hard reset in a controlled way. A one-cycle start pulse begins the sequence. The block drives an active-low reset line low and keeps it low for a minimum hold time. It then waits until the host reports that the external clocks are stable, and after that waits a further pre-release time. Only then does it release the line.

After release, the block waits for two intervals in turn: the device's internal start-up timer, then the serial link settling time. It then samples three kinds of status from the device: a flag saying the internal reset timer has expired, a vector of clock out-of-lock flags, and a flag saying the PLL has stabilised. The reset worked only if the expiry flag is set, every out-of-lock flag is clear, and the PLL flag is set.

If the check fails, the whole sequence runs again, up to `MAX_TRY` attempts in total. The block then reports either done or fail. All intervals are parameters counted in clock cycles. The status inputs pass through a synchroniser of `SYNC_STAGES` flops before they are used. Parameter values must be at least 1.

Top module: `devrst_seq`

## Requirements
- R1: While `rst` is high and after it falls, before any start pulse: `dev_rst_n`=1, `busy`=0, `done`=0, `fail`=0, `attempt`=0.
- R2: A `start` pulse seen in idle makes, from the next cycle on: `dev_rst_n`=0, `busy`=1, `done`=0, `fail`=0, `attempt`=1. The outcome flags of the previous run are cleared.
- R3: If `clk_stable` stays high, each attempt keeps `dev_rst_n` low for exactly `HOLD_CYC`+1+`PRE_CYC` cycles.
- R4: If `clk_stable` is low when the hold time ends, the line stays low. It is released exactly `PRE_CYC` cycles after the first clock edge at which `clk_stable` is seen high again.
- R5: After each release, `dev_rst_n` stays high for exactly `INT_CYC`+`SET_CYC`+1 cycles; the last of these is the status check. The outcome of the attempt then appears.
- R6: The check passes only when, after synchronisation, `stat_expired`=1, `stat_lock_loss` is all zeros and `stat_pll_ok`=1. A pass sets `done`=1 and `busy`=0, leaves `dev_rst_n`=1, and leaves `attempt` at the number of the attempt that passed.
- R7: A failed check while `attempt` < `MAX_TRY` drives `dev_rst_n` low again in the very next cycle and increments `attempt` by one.
- R8: A failed check on attempt `MAX_TRY` sets `fail`=1, `busy`=0 and `done`=0, releases `dev_rst_n` to 1, and leaves `attempt`=`MAX_TRY`.
- R9: A `start` pulse while `busy`=1 has no effect: the attempt number and the timing of the line do not change.
- R10: `done`, `fail` and `attempt` hold their values in idle until the next start, whatever `clk_stable` and the status inputs do. `dev_rst_n` stays 1 in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches a reset sequence |
| clk_stable | input | 1 | High when the device's external clocks and reference select are stable |
| stat_expired | input | 1 | Device flag: internal reset timer has expired |
| stat_lock_loss | input | LOCK_W | Device flags: clock domains out of lock (any 1 means failure) |
| stat_pll_ok | input | 1 | Device flag: PLL has stabilised |
| dev_rst_n | output | 1 | Active-low reset line to the device |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence passed its status check |
| fail | output | 1 | Last sequence used up all attempts without passing |
| attempt | output | $clog2(MAX_TRY+1) | Number of the current or last attempt (1-based; 0 before the first start) |

## Verification
A phase counter that is off by one shows up at once as a low or high interval on `dev_rst_n` that is one cycle too short or too long. The bench measures these intervals exactly on every attempt.

A retry decision that goes wrong shows up within the same check cycle: the line is re-asserted when it should not be, or `attempt` lands on the wrong value. A bad pass condition ends the run with the wrong choice between `done` and `fail`. Because a different flag is faulted on each attempt, that error also shows up in the final `attempt` value.

// File: rtl/devrst_pkg.sv
package devrst_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_HOLD  = 3'd1,
    PH_WCLK  = 3'd2,
    PH_PRE   = 3'd3,
    PH_INT   = 3'd4,
    PH_SET   = 3'd5,
    PH_CHECK = 3'd6
  } phase_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/devrst_timer.sv
module devrst_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/devrst_judge.sv
module devrst_judge #(
  parameter int LOCK_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              expired_i,
  input  logic [LOCK_W-1:0] lock_loss_i,
  input  logic              pll_ok_i,
  output logic              status_ok
);

  localparam int VW = LOCK_W + 2;

  logic [VW-1:0] stage [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else     stage[s] <= {pll_ok_i, lock_loss_i, expired_i};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else     stage[s] <= stage[s-1];
      end
    end
  end

  logic              s_exp;
  logic              s_pll;
  logic [LOCK_W-1:0] s_lock;

  assign s_exp  = stage[SYNC_STAGES-1][0];
  assign s_lock = stage[SYNC_STAGES-1][LOCK_W:1];
  assign s_pll  = stage[SYNC_STAGES-1][VW-1];

  always_ff @(posedge clk) begin
    if (rst) status_ok <= 1'b0;
    else     status_ok <= s_exp & s_pll & ~(|s_lock);
  end

endmodule

// File: rtl/devrst_fsm.sv
module devrst_fsm
  import devrst_pkg::*;
#(
  parameter int HOLD_CYC = 4,
  parameter int PRE_CYC  = 4,
  parameter int INT_CYC  = 8,
  parameter int SET_CYC  = 2,
  parameter int MAX_TRY  = 3,
  parameter int CW       = 8,
  parameter int AW       = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          clk_stable,
  input  logic          tmr_zero,
  input  logic          status_ok,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          dev_rst_n,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] attempt
);

  localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] PRE_LD  = CW'(PRE_CYC - 1);
  localparam logic [CW-1:0] INT_LD  = CW'(INT_CYC - 1);
  localparam logic [CW-1:0] SET_LD  = CW'(SET_CYC - 1);
  localparam logic [AW-1:0] LAST    = AW'(MAX_TRY);

  phase_t ph, ph_n;
  logic   more_left;

  assign more_left = (attempt < LAST);

  always_comb begin
    ph_n     = ph;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (ph)
      PH_IDLE: if (start) begin
        ph_n = PH_HOLD; tmr_load = 1'b1; tmr_val = HOLD_LD;
      end
      PH_HOLD: if (tmr_zero) ph_n = PH_WCLK;
      PH_WCLK: if (clk_stable) begin
        ph_n = PH_PRE; tmr_load = 1'b1; tmr_val = PRE_LD;
      end
      PH_PRE: if (tmr_zero) begin
        ph_n = PH_INT; tmr_load = 1'b1; tmr_val = INT_LD;
      end
      PH_INT: if (tmr_zero) begin
        ph_n = PH_SET; tmr_load = 1'b1; tmr_val = SET_LD;
      end
      PH_SET: if (tmr_zero) ph_n = PH_CHECK;
      PH_CHECK: begin
        if (!status_ok && more_left) begin
          ph_n = PH_HOLD; tmr_load = 1'b1; tmr_val = HOLD_LD;
        end else begin
          ph_n = PH_IDLE;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      dev_rst_n <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      attempt   <= '0;
    end else begin
      ph <= ph_n;
      case (ph)
        PH_IDLE: if (start) begin
          dev_rst_n <= 1'b0;
          busy      <= 1'b1;
          done      <= 1'b0;
          fail      <= 1'b0;
          attempt   <= AW'(1);
        end
        PH_PRE: if (tmr_zero) dev_rst_n <= 1'b1;
        PH_CHECK: begin
          if (status_ok) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else if (more_left) begin
            dev_rst_n <= 1'b0;
            attempt   <= attempt + 1'b1;
          end else begin
            busy <= 1'b0;
            fail <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/devrst_seq.sv
module devrst_seq
  import devrst_pkg::*;
#(
  parameter int HOLD_CYC    = 200000,
  parameter int PRE_CYC     = 200000,
  parameter int INT_CYC     = 1500000,
  parameter int SET_CYC     = 100000,
  parameter int LOCK_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_TRY     = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         clk_stable,
  input  logic                         stat_expired,
  input  logic [LOCK_W-1:0]            stat_lock_loss,
  input  logic                         stat_pll_ok,
  output logic                         dev_rst_n,
  output logic                         busy,
  output logic                         done,
  output logic                         fail,
  output logic [$clog2(MAX_TRY+1)-1:0] attempt
);

  localparam int AW = $clog2(MAX_TRY + 1);
  localparam int CW = $clog2(max_u(max_u(HOLD_CYC, PRE_CYC), max_u(INT_CYC, SET_CYC)) + 1);

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          status_ok;

  devrst_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  devrst_judge #(.LOCK_W(LOCK_W), .SYNC_STAGES(SYNC_STAGES)) u_judge (
    .clk         (clk),
    .rst         (rst),
    .expired_i   (stat_expired),
    .lock_loss_i (stat_lock_loss),
    .pll_ok_i    (stat_pll_ok),
    .status_ok   (status_ok)
  );

  devrst_fsm #(
    .HOLD_CYC (HOLD_CYC),
    .PRE_CYC  (PRE_CYC),
    .INT_CYC  (INT_CYC),
    .SET_CYC  (SET_CYC),
    .MAX_TRY  (MAX_TRY),
    .CW       (CW),
    .AW       (AW)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .clk_stable (clk_stable),
    .tmr_zero   (tmr_zero),
    .status_ok  (status_ok),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .dev_rst_n  (dev_rst_n),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .attempt    (attempt)
  );

endmodule

// File: rtl/devrst_chk.sv
module devrst_chk #(
  parameter int HOLD_CYC = 4,
  parameter int PRE_CYC  = 4,
  parameter int MAX_TRY  = 3,
  parameter int AW       = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          dev_rst_n,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic [AW-1:0] attempt,
  input logic          status_ok
);

  logic [31:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)             low_cnt <= '0;
    else if (!dev_rst_n) low_cnt <= low_cnt + 1;
    else                 low_cnt <= '0;
  end

  // R10
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> dev_rst_n);

  // R6
  outcome_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));

  // R6
  pass_needs_status_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(status_ok));

  // R8
  fail_at_last_try_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> (attempt == AW'(MAX_TRY)) && !$past(status_ok));

  // R7
  retry_increments_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(dev_rst_n) && $past(busy)) |-> (attempt == $past(attempt) + 1'b1));

  // R3
  low_time_min_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(dev_rst_n) && busy) |-> (low_cnt >= 32'(HOLD_CYC + 1 + PRE_CYC)));

  // R9
  attempt_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> (attempt >= $past(attempt)) && (attempt != '0));

endmodule

bind devrst_seq devrst_chk #(
  .HOLD_CYC (HOLD_CYC),
  .PRE_CYC  (PRE_CYC),
  .MAX_TRY  (MAX_TRY),
  .AW       ($clog2(MAX_TRY + 1))
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dev_rst_n (dev_rst_n),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .attempt   (attempt),
  .status_ok (status_ok)
);

// File: tb/devrst_seq_tb.sv
module devrst_seq_tb;

  localparam int T_HOLD = 6;
  localparam int T_PRE  = 5;
  localparam int T_INT  = 20;
  localparam int T_SET  = 4;
  localparam int NLOCK  = 4;
  localparam int TRIES  = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             clk_stable = 1'b1;
  logic             stat_expired = 1'b0;
  logic [NLOCK-1:0] stat_lock_loss = '1;
  logic             stat_pll_ok = 1'b0;
  logic             dev_rst_n;
  logic             busy, done, fail;
  logic [1:0]       attempt;

  int checks = 0;
  int errors = 0;
  int fplan [4];
  int since_rel = 0;

  always #5 clk = ~clk;

  devrst_seq #(
    .HOLD_CYC(T_HOLD), .PRE_CYC(T_PRE), .INT_CYC(T_INT), .SET_CYC(T_SET),
    .LOCK_W(NLOCK), .SYNC_STAGES(2), .MAX_TRY(TRIES)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .clk_stable(clk_stable),
    .stat_expired(stat_expired), .stat_lock_loss(stat_lock_loss),
    .stat_pll_ok(stat_pll_ok), .dev_rst_n(dev_rst_n), .busy(busy),
    .done(done), .fail(fail), .attempt(attempt)
  );

  // Device model: flags settle a few cycles after release, per the fault code
  // of the current attempt (0 good, 1 no expiry, 2 PLL bad, 3+ lock bit).
  always @(negedge clk) begin
    if (!dev_rst_n) begin
      since_rel      = 0;
      stat_expired   = 1'b0;
      stat_pll_ok    = 1'b0;
      stat_lock_loss = '1;
    end else begin
      if (since_rel < 1000) since_rel = since_rel + 1;
      if (since_rel == 3) begin
        stat_expired   = (fplan[attempt] != 1);
        stat_pll_ok    = (fplan[attempt] != 2);
        stat_lock_loss = '0;
        if (fplan[attempt] >= 3) stat_lock_loss[fplan[attempt]-3] = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int first_good(input int a, input int b, input int c);
    if (a == 0) return 1;
    if (b == 0) return 2;
    if (c == 0) return 3;
    return 0;
  endfunction

  task automatic run_trial(input int fa, input int fb, input int fc,
                           input int stall, input bit poke);
    int good_at, last, low, hi;
    fplan[1] = fa; fplan[2] = fb; fplan[3] = fc;
    good_at = first_good(fa, fb, fc);
    last    = (good_at == 0) ? TRIES : good_at;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(dev_rst_n == 0 && busy && !done && !fail, "R2", "start state",
          {dev_rst_n, busy, done, fail}, 4'b0100);
    check(attempt == 1, "R2", "attempt after start", attempt, 1);
    for (int a = 1; a <= last; a++) begin
      if (stall == 0) begin
        low = 1;
        while (dev_rst_n == 0 && low < 1000) begin
          @(negedge clk);
          start = (poke && a == 1 && low == 2);
          if (!dev_rst_n) low++;
          if (poke && a == 1 && low == 4)
            check(attempt == 1 && !dev_rst_n, "R9", "start while busy",
                  attempt, 1);
        end
        start = 1'b0;
        check(low == T_HOLD + 1 + T_PRE, "R3", "low cycles", low,
              T_HOLD + 1 + T_PRE);
      end else begin
        clk_stable = 1'b0;
        repeat (stall) @(negedge clk);
        check(dev_rst_n == 0, "R4", "held while clocks unstable", dev_rst_n, 0);
        clk_stable = 1'b1;
        repeat (T_PRE) @(negedge clk);
        check(dev_rst_n == 0, "R4", "still low before pre time ends", dev_rst_n, 0);
        @(negedge clk);
        check(dev_rst_n == 1, "R4", "released after pre time", dev_rst_n, 1);
      end
      hi = 1;
      while (dev_rst_n && busy && hi < 1000) begin
        @(negedge clk);
        if (dev_rst_n && busy) hi++;
      end
      check(hi == T_INT + T_SET + 1, "R5", "high cycles to outcome", hi,
            T_INT + T_SET + 1);
      if (a < last) begin
        check(!dev_rst_n && busy && !done && !fail, "R7", "re-asserted",
              {dev_rst_n, busy, done, fail}, 4'b0100);
        check(attempt == a + 1, "R7", "attempt incremented", attempt, a + 1);
      end else if (good_at != 0) begin
        check(done && !fail && !busy && dev_rst_n, "R6", "pass flags",
              {dev_rst_n, busy, done, fail}, 4'b1010);
        check(attempt == a, "R6", "attempt at pass", attempt, a);
      end else begin
        check(fail && !done && !busy && dev_rst_n, "R8", "fail flags",
              {dev_rst_n, busy, done, fail}, 4'b1001);
        check(attempt == TRIES, "R8", "attempt at fail", attempt, TRIES);
      end
    end
    // idle: outcome must hold while inputs wiggle
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      clk_stable = i[0];
    end
    clk_stable = 1'b1;
    check(done == (good_at != 0) && fail == (good_at == 0) && dev_rst_n && !busy,
          "R10", "outcome held in idle", {done, fail}, (good_at != 0) ? 2 : 1);
    check(attempt == last, "R10", "attempt held in idle", attempt, last);
  endtask

  initial begin
    int pick [3];
    void'($urandom(32'd20240611));
    fplan[0] = 0;
    repeat (3) @(negedge clk);
    check(dev_rst_n && !busy && !done && !fail && attempt == 0, "R1",
          "state in reset", {dev_rst_n, busy, done, fail}, 4'b1000);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(dev_rst_n && !busy && !done && !fail && attempt == 0, "R1",
          "state after reset", {dev_rst_n, busy, done, fail}, 4'b1000);

    run_trial(0, 0, 0, 0, 1'b0);
    run_trial(1, 0, 0, 0, 1'b0);
    run_trial(2, 3, 0, 0, 1'b0);
    run_trial(4, 5, 6, 0, 1'b0);
    run_trial(1, 2, 3, 0, 1'b0);
    run_trial(0, 0, 0, T_HOLD + 3, 1'b0);
    run_trial(3, 0, 0, T_HOLD + 8, 1'b0);
    run_trial(0, 0, 0, 0, 1'b1);
    run_trial(2, 2, 2, 0, 1'b1);

    for (int t = 0; t < 30; t++) begin
      for (int j = 0; j < 3; j++)
        pick[j] = ($urandom_range(0, 1) == 1) ? 0 : int'($urandom_range(1, 2 + NLOCK));
      run_trial(pick[0], pick[1], pick[2],
                ($urandom_range(0, 2) == 0) ? T_HOLD + 2 + int'($urandom_range(0, 6)) : 0,
                1'($urandom_range(0, 1)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule